// File: doc/BRIEF.md
# Run-Time Tap Selection LFSR Sequencer

This block is a small multi-cycle engine that builds an 8-bit pseudorandom value. A caller sets an 8-bit tap-select vector and an 8-bit step count, then pulses start. The block first walks the tap-select vector, one bit position per clock, and takes up to two feedback positions from it. It then seeds an 8-bit shift register with 1 and advances it exactly the requested number of times. Each advance shifts the register left and feeds the XOR of the two chosen bits back into bit 0. When the run is done, the final register state is published.

Start and busy are the only handshake. Start is honoured only while busy is low. Both inputs are captured on the accepted start edge, so the caller may change them freely while the run is in progress. There is no back-pressure. A published value stays on the outputs, unchanged, until the next run completes, so the caller may read it at any time after busy falls. A nine-bit packed output carries busy in bit 0 and the value in bits 8:1, for callers that want a single bus.

Top module: `lfsr_seq_top`

## Requirements
- R1: A synchronous active-high reset sends the block to idle. After reset, busy_o is 0, value_o is 8'h01 and result_bus_o is 9'h002. This holds even when reset is applied in the middle of a run.
- R2: A start_i high sampled while busy_o is low (idle or the one-cycle finish state) is accepted. It captures tap_sel_i and step_count_i, and busy_o is 1 in the very next cycle.
- R3: The tap scan examines one captured bit per cycle, from bit 0 upward. The lowest set bit becomes tap A and the next set bit above it becomes tap B. The scan stops on finding tap B (it takes p+1 cycles, where p is tap B's position); otherwise it takes 8 cycles.
- R4: Tap A defaults to bit 1 and tap B defaults to bit 0. A default is kept for any tap the scan does not find, so with no bits set the taps are 1 and 0, and with one bit k set they are k and 0.
- R5: Each run starts from register value 8'h01, whatever earlier runs produced.
- R6: One step makes the new register equal to {old[6:0], old[tapA] ^ old[tapB]}.
- R7: The register is advanced exactly step_count times. A count of 0 publishes 8'h01.
- R8: busy_o stays high for exactly S + N + 2 cycles, where S is the scan length from R3 and N is the step count. value_o takes its new value on the same edge where busy_o falls.
- R9: While busy_o is high, start_i and changes on tap_sel_i or step_count_i have no effect on the run's result or its length.
- R10: While busy_o is low and no run completes, value_o holds steady, whatever happens on tap_sel_i and step_count_i.
- R11: result_bus_o[0] equals busy_o and result_bus_o[8:1] equals value_o at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Run request, sampled while busy_o is low |
| tap_sel_i | input | 8 | Tap-select vector; bit k set asks for a feedback tap at bit k |
| step_count_i | input | 8 | Number of register advances for the run |
| busy_o | output | 1 | High while a run is in progress |
| value_o | output | 8 | Most recently published register value |
| result_bus_o | output | 9 | Packed form: bit 0 busy, bits 8:1 value |

## Verification
The bench pushes tap vectors with zero, one, two and more than two set bits. A scanner that failed to stop after the second tap, or that picked the highest bits, would give wrong values and wrong busy lengths. A scanner that mishandled the defaults would go wrong on the all-zero and single-bit vectors: a lone bit 0 gives taps 0 and 0, which drains the register to zero. A step count of 0 catches an off-by-one in the loop bound, which would publish a shifted seed, and a count of 255 stresses the counter's top value. The bench also fires start and new inputs in the middle of a run, checks that the value holds in idle while the inputs move, runs back to back to catch a missing reseed, and applies reset in the middle of a run.

// File: rtl/lfsr_seq_pkg.sv
package lfsr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEED = 3'd1,
    ST_SCAN = 3'd2,
    ST_STEP = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;

endpackage

// File: rtl/lfsr_tap_finder.sv
module lfsr_tap_finder #(
  parameter int WIDTH    = 8,
  parameter int IDX_W    = $clog2(WIDTH),
  parameter int DEF_TAPA = 1,
  parameter int DEF_TAPB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] sel_i,
  input  logic             scan_i,
  output logic [IDX_W-1:0] tap_a_o,
  output logic [IDX_W-1:0] tap_b_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(WIDTH - 1);
  localparam logic [IDX_W-1:0] TAPA_RST = IDX_W'(DEF_TAPA);
  localparam logic [IDX_W-1:0] TAPB_RST = IDX_W'(DEF_TAPB);

  logic [WIDTH-1:0] sel_q;
  logic [IDX_W-1:0] pos_q;
  logic [1:0]       hits_q;
  logic             bit_hit;

  assign bit_hit = sel_q[pos_q];
  assign done_o  = scan_i && ((pos_q == LAST_POS) || (bit_hit && (hits_q != 2'd0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      pos_q   <= '0;
      hits_q  <= 2'd0;
      tap_a_o <= TAPA_RST;
      tap_b_o <= TAPB_RST;
    end else if (capture_i) begin
      sel_q   <= sel_i;
      pos_q   <= '0;
      hits_q  <= 2'd0;
      tap_a_o <= TAPA_RST;
      tap_b_o <= TAPB_RST;
    end else if (scan_i) begin
      if (bit_hit) begin
        if (hits_q == 2'd0) begin
          tap_a_o <= pos_q;
          hits_q  <= 2'd1;
        end else if (hits_q == 2'd1) begin
          tap_b_o <= pos_q;
          hits_q  <= 2'd2;
        end
      end
      if (pos_q != LAST_POS) begin
        pos_q <= pos_q + IDX_W'(1);
      end
    end
  end

  // R3: the scan visits exactly one new position per cycle
  p_scan_one_per_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (scan_i && !done_o && !capture_i) |=> (pos_q == $past(pos_q) + IDX_W'(1)));

  // R3: once both taps are found, tap B lies above tap A
  p_tap_order_r3: assert property (@(posedge clk) disable iff (rst)
    (hits_q == 2'd2) |-> (tap_b_o > tap_a_o));

  // R4: every capture starts from the default taps
  p_default_taps_r4: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (tap_a_o == TAPA_RST && tap_b_o == TAPB_RST && hits_q == 2'd0));

endmodule

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core #(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] tap_a_i,
  input  logic [IDX_W-1:0] tap_b_i,
  output logic [WIDTH-1:0] reg_o
);

  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  logic feedback;
  assign feedback = reg_o[tap_a_i] ^ reg_o[tap_b_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_o <= SEED;
    end else if (seed_i) begin
      reg_o <= SEED;
    end else if (step_i) begin
      reg_o <= {reg_o[WIDTH-2:0], feedback};
    end
  end

  // R5: seeding always gives the value 1
  p_seed_value_r5: assert property (@(posedge clk) disable iff (rst)
    seed_i |=> (reg_o == SEED));

  // R6: one step is a left shift plus the tap XOR in bit 0
  p_step_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !seed_i) |=> (reg_o[WIDTH-1:1] == $past(reg_o[WIDTH-2:0])
                             && reg_o[0] == ($past(reg_o[tap_a_i]) ^ $past(reg_o[tap_b_i]))));

  // R7: the register is untouched when not seeded or stepped
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!seed_i && !step_i) |=> $stable(reg_o));

endmodule

// File: rtl/lfsr_seq_ctrl.sv
module lfsr_seq_ctrl
  import lfsr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] steps_i,
  input  logic             scan_done_i,
  output logic             capture_o,
  output logic             seed_o,
  output logic             scan_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             busy_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] steps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle_like;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    seed_o    = 1'b0;
    scan_o    = 1'b0;
    step_o    = 1'b0;
    finish_o  = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          capture_o = 1'b1;
          state_d   = ST_SEED;
        end else begin
          state_d   = ST_IDLE;
        end
      end
      ST_SEED: begin
        seed_o  = 1'b1;
        state_d = ST_SCAN;
      end
      ST_SCAN: begin
        scan_o = 1'b1;
        if (scan_done_i) begin
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        if (cnt_q == steps_q) begin
          finish_o = 1'b1;
          state_d  = ST_DONE;
        end else begin
          step_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_o  <= 1'b0;
      steps_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      busy_o  <= (state_d == ST_SEED) || (state_d == ST_SCAN) || (state_d == ST_STEP);
      if (capture_o) begin
        steps_q <= steps_i;
      end
      if (seed_o) begin
        cnt_q <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R2: an accepted start raises busy in the next cycle
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    (idle_like && start_i) |=> busy_o);

  // R9: a start seen while busy does not disturb the state sequence
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (state_q == ST_STEP) && !finish_o) |=> (state_q == ST_STEP));

  // R7: the step counter never runs past the captured count
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP) |-> (cnt_q <= steps_q));

  // R8: busy is low in the finish state
  p_busy_low_done_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> !busy_o);

endmodule

// File: rtl/lfsr_seq_top.sv
module lfsr_seq_top #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] tap_sel_i,
  input  logic [CNT_W-1:0] step_count_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] value_o,
  output logic [WIDTH:0]   result_bus_o
);

  localparam int IDX_W = $clog2(WIDTH);

  logic             capture;
  logic             seed;
  logic             scan;
  logic             step;
  logic             finish;
  logic             scan_done;
  logic [IDX_W-1:0] tap_a;
  logic [IDX_W-1:0] tap_b;
  logic [WIDTH-1:0] shift_reg;
  logic [WIDTH-1:0] value_q;

  lfsr_seq_ctrl #(.CNT_W(CNT_W)) ctrl_u (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .steps_i    (step_count_i),
    .scan_done_i(scan_done),
    .capture_o  (capture),
    .seed_o     (seed),
    .scan_o     (scan),
    .step_o     (step),
    .finish_o   (finish),
    .busy_o     (busy_o)
  );

  lfsr_tap_finder #(.WIDTH(WIDTH), .IDX_W(IDX_W)) taps_u (
    .clk      (clk),
    .rst      (rst),
    .capture_i(capture),
    .sel_i    (tap_sel_i),
    .scan_i   (scan),
    .tap_a_o  (tap_a),
    .tap_b_o  (tap_b),
    .done_o   (scan_done)
  );

  lfsr_shift_core #(.WIDTH(WIDTH), .IDX_W(IDX_W)) core_u (
    .clk    (clk),
    .rst    (rst),
    .seed_i (seed),
    .step_i (step),
    .tap_a_i(tap_a),
    .tap_b_i(tap_b),
    .reg_o  (shift_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= WIDTH'(1);
    end else if (finish) begin
      value_q <= shift_reg;
    end
  end

  assign value_o      = value_q;
  assign result_bus_o = {value_q, busy_o};

  // R10: the published value only moves on a completing run
  p_value_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !finish) |=> $stable(value_o));

  // R8: the result lands on the edge where busy drops
  p_result_with_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!busy_o && value_o == $past(shift_reg)));

endmodule

// File: tb/lfsr_seq_top_tb_top.sv
module lfsr_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [7:0] tap_sel;
  logic [7:0] steps_in;
  logic       busy;
  logic [7:0] value;
  logic [8:0] bus;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lfsr_seq_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .tap_sel_i   (tap_sel),
    .step_count_i(steps_in),
    .busy_o      (busy),
    .value_o     (value),
    .result_bus_o(bus)
  );

  // Vectors: {tap select, step count}
  localparam logic [15:0] VECS [12] = '{
    16'h0300, 16'h8410, 16'h0005, 16'h0109, 16'h2007, 16'hFF0C,
    16'hB8FF, 16'h600A, 16'h8001, 16'h1234, 16'h0201, 16'hC064
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] sel, input logic [7:0] n,
                       output int scan_cyc, output logic [7:0] res);
    int ta = 1;
    int tb = 0;
    int hits = 0;
    scan_cyc = 8;
    for (int k = 0; k < 8; k++) begin
      if (sel[k] && hits < 2) begin
        if (hits == 0) ta = k;
        else begin
          tb = k;
          scan_cyc = k + 1;
        end
        hits++;
      end
    end
    res = 8'h01;
    for (int i = 0; i < int'(n); i++) res = {res[6:0], res[ta] ^ res[tb]};
  endtask

  task automatic run(input logic [7:0] sel, input logic [7:0] n,
                     input bit disturb, input string tag);
    int scan_cyc;
    logic [7:0] exp_val;
    int cyc;
    model(sel, n, scan_cyc, exp_val);
    @(negedge clk);
    tap_sel = sel; steps_in = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    cyc = 1;
    while (cyc < 2000) begin
      @(negedge clk);
      if (!busy) break;
      cyc++;
      if (disturb && cyc == 2) begin
        start = 1'b1; tap_sel = ~sel; steps_in = n + 8'd3;
      end
      if (disturb && cyc == 3) start = 1'b0;
    end
    start = 1'b0;
    check(cyc == scan_cyc + int'(n) + 2, {"R3 R8 ", tag}, "busy length",
          cyc, scan_cyc + int'(n) + 2);
    check(value == exp_val, {"R6 R7 ", tag}, "value", value, exp_val);
    check(bus == {exp_val, 1'b0}, "R11", "packed bus", bus, {exp_val, 1'b0});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    rst = 1'b1; start = 1'b0; tap_sel = 8'h00; steps_in = 8'h00;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    check(value == 8'h01, "R1", "reset value", value, 1);
    check(bus == 9'h002, "R1 R11", "reset bus", bus, 9'h002);
    rst = 1'b0;

    for (int v = 0; v < 12; v++) begin
      run(VECS[v][15:8], VECS[v][7:0], 1'b0, "table");
    end

    // R4: defaults with no taps, with a lone bit 0, with a lone high bit
    run(8'h00, 8'd20, 1'b0, "R4 none");
    run(8'h01, 8'd8, 1'b0, "R4 bit0");
    run(8'h40, 8'd17, 1'b0, "R4 bit6");

    // R7: zero steps reports the seed; R5: back to back reseeds
    run(8'hB8, 8'd200, 1'b0, "R5 first");
    run(8'h0C, 8'd0, 1'b0, "R5 R7 zero");

    // R9: start and input changes mid-run are ignored
    run(8'h12, 8'd30, 1'b1, "R9 disturb");
    run(8'h03, 8'd2, 1'b1, "R9 short");

    // R10: value holds in idle while inputs move
    held = value;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      tap_sel = 8'(i * 37); steps_in = 8'(i * 11);
    end
    check(value == held, "R10", "idle hold", value, held);
    check(busy == 1'b0, "R10", "idle busy", busy, 0);

    // R1: reset during a run
    @(negedge clk);
    tap_sel = 8'h81; steps_in = 8'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0, "R1", "mid-run reset busy", busy, 0);
    check(value == 8'h01, "R1", "mid-run reset value", value, 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "stays idle after reset", busy, 0);

    run(8'h88, 8'd33, 1'b0, "after reset");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule